// File: doc/BRIEF.md
# Row-Buffered DRAM Array Emulator

This block is a synchronous, cycle-level model of a small square dynamic-memory bit array. It has a single row of sense-amplifier storage, called the row latch. A flat address is split in two. The high half picks a row and the low half picks a bit inside that row. Opening a row copies all of its bits into the row latch in one cycle. The same cycle wipes the array cells, which models a destructive read: the array copy of that row is invalid until it is restored. Column reads and writes are then served from the latch alone. Closing the row, or opening a different one, restores the latch contents into the array.

The block is meant for models and test fabrics that need the open-row, closed-row and writeback ordering of a dynamic memory without its analog behaviour. A user opens a row, performs any number of single-cycle column accesses, and closes the row. `busy` marks the cycles in which the block is sensing or restoring a row.

Top module: `dram_row_emu`

## Requirements
- R1: The address is `2*HALF_W` bits wide. Bits `[2*HALF_W-1:HALF_W]` select the row and bits `[HALF_W-1:0]` select the column. With the default `HALF_W=2`, address 6 (4'b0110) is row 1, column 2.
- R2: A `row_open` strobe taken while no row is open gives exactly one cycle with `busy`=1. After that cycle `row_active`=1 and `busy`=0. `busy` and `row_active` are never high together.
- R3: While a row is open, the array copy of that row is marked invalid.
- R4: A `row_close` strobe taken while a row is open gives one writeback cycle with `busy`=1. After that cycle `row_active`=0. The row's data is kept in the array, and reopening the row returns it.
- R5: A column write (`col_acc`=1, `col_we`=1) stores `wdata` into the selected bit of the open row's latch. The value reaches the array through the writeback.
- R6: A column read (`col_acc`=1, `col_we`=0) on an open row sets `rdata` to the latched bit of the selected column one cycle later. `rdata_vld` is high for that single cycle.
- R7: A column access while no row is open is ignored. It does not change any stored bit and does not raise `rdata_vld`. It raises `acc_err` for one cycle in the following cycle.
- R8: A `row_open` strobe taken while a row is open first writes back the old row, then senses the new one. This gives two `busy` cycles before `row_active` returns to 1.
- R9: While `busy`=1, the `row_open` and `row_close` strobes are ignored. A column access made in that time is treated as in R7.
- R10: After reset, no row is open, `busy`, `acc_err` and `rdata_vld` are 0, and every stored bit is 0.
- R11: If `row_open` and `row_close` are both high while a row is open, the open request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 2*HALF_W | Flat address: row in the high half, column in the low half |
| row_open | input | 1 | Request to open the row selected by `addr` |
| row_close | input | 1 | Request to write back and close the open row |
| col_acc | input | 1 | Column access strobe |
| col_we | input | 1 | 1 = column write, 0 = column read |
| wdata | input | 1 | Bit to write |
| rdata | output | 1 | Bit read from the latched row |
| rdata_vld | output | 1 | `rdata` is valid this cycle |
| busy | output | 1 | Sense or writeback cycle in progress |
| row_active | output | 1 | A row is open and accepts column accesses |
| acc_err | output | 1 | The previous cycle held a rejected column access |

## Verification
A walked table opens rows, writes a mix of ones and zeros, and reads back both written and unwritten columns. It also switches rows without closing them first. A wrong row/column split or a lost writeback therefore shows up as a wrong bit in another row or column. Directed cases then do the following:
- Access the block with no row open, to separate an ignored access from a silently applied one.
- Send `row_open` and `row_close` together, to confirm the open request wins.
- Send strobes and accesses during a writeback cycle.
- Count `busy` cycles, which tells a plain open apart from a row switch.

// File: rtl/dram_emu_pkg.sv
package dram_emu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SENSE = 2'd1,
        ST_OPEN  = 2'd2,
        ST_WB    = 2'd3
    } ctrl_state_e;

    typedef struct packed {
        logic sense;
        logic wback;
        logic lat_rd;
        logic lat_wr;
    } arr_cmd_t;

    function automatic logic is_busy_state(input ctrl_state_e s);
        return (s == ST_SENSE) || (s == ST_WB);
    endfunction

endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
    parameter int HALF_W = 2
) (
    input  logic [2*HALF_W-1:0] addr,
    output logic [HALF_W-1:0]   row,
    output logic [HALF_W-1:0]   col
);
    // row in the high half, column in the low half
    assign row = addr[2*HALF_W-1:HALF_W];
    assign col = addr[HALF_W-1:0];
endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
    parameter int HALF_W = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sense_en,
    input  logic [HALF_W-1:0]      sense_row,
    input  logic                   wb_en,
    input  logic [HALF_W-1:0]      wb_row,
    input  logic [(1<<HALF_W)-1:0] wb_data,
    output logic [(1<<HALF_W)-1:0] sense_data,
    output logic [(1<<HALF_W)-1:0] row_valid
);
    localparam int ROWS = 1 << HALF_W;
    localparam int COLS = 1 << HALF_W;

    logic [COLS-1:0] cells [ROWS];
    logic [ROWS-1:0] hit_wb;
    logic [ROWS-1:0] hit_sense;

    for (genvar r = 0; r < ROWS; r++) begin : g_row_dec
        assign hit_wb[r]    = wb_en    && (wb_row    == HALF_W'(r));
        assign hit_sense[r] = sense_en && (sense_row == HALF_W'(r));
    end

    assign sense_data = cells[sense_row];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) begin
                cells[r]     <= '0;
                row_valid[r] <= 1'b1;
            end
        end else begin
            for (int r = 0; r < ROWS; r++) begin
                if (hit_wb[r]) begin
                    cells[r]     <= wb_data;
                    row_valid[r] <= 1'b1;
                end else if (hit_sense[r]) begin
                    // destructive read: charge is gone until restored
                    cells[r]     <= '0;
                    row_valid[r] <= 1'b0;
                end
            end
        end
    end

    AST_NO_WB_WITH_SENSE: assert property (@(posedge clk) disable iff (rst)
        !(wb_en && sense_en)); // R8
    AST_SENSE_VALID_ROW: assert property (@(posedge clk) disable iff (rst)
        sense_en |-> row_valid[sense_row]); // R3
endmodule

// File: rtl/dram_row_latch.sv
module dram_row_latch #(
    parameter int HALF_W = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load_en,
    input  logic [(1<<HALF_W)-1:0] load_data,
    input  logic [HALF_W-1:0]      col,
    input  logic                   rd_en,
    input  logic                   wr_en,
    input  logic                   wbit,
    output logic [(1<<HALF_W)-1:0] latch_q,
    output logic                   rdata,
    output logic                   rdata_vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q   <= '0;
            rdata     <= 1'b0;
            rdata_vld <= 1'b0;
        end else begin
            if (load_en) begin
                latch_q <= load_data;
            end else if (wr_en) begin
                latch_q[col] <= wbit;
            end
            rdata_vld <= rd_en;
            if (rd_en) begin
                rdata <= latch_q[col];
            end
        end
    end

    AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        load_en |-> !wr_en); // R5
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en)); // R6
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
    import dram_emu_pkg::*;
#(
    parameter int HALF_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              row_open,
    input  logic              row_close,
    input  logic              col_acc,
    input  logic              col_we,
    input  logic [HALF_W-1:0] req_row,
    output arr_cmd_t          cmd,
    output logic [HALF_W-1:0] cur_row,
    output logic [HALF_W-1:0] nxt_row,
    output logic              busy,
    output logic              active,
    output logic              acc_err
);
    ctrl_state_e state;
    logic        reopen_q;
    logic        acc_ok;

    assign acc_ok     = col_acc && (state == ST_OPEN);
    assign cmd.sense  = (state == ST_SENSE);
    assign cmd.wback  = (state == ST_WB);
    assign cmd.lat_rd = acc_ok && !col_we;
    assign cmd.lat_wr = acc_ok && col_we;
    assign busy       = is_busy_state(state);
    assign active     = (state == ST_OPEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_row  <= '0;
            nxt_row  <= '0;
            reopen_q <= 1'b0;
            acc_err  <= 1'b0;
        end else begin
            acc_err <= col_acc && (state != ST_OPEN);
            unique case (state)
                ST_IDLE: begin
                    if (row_open) begin
                        nxt_row <= req_row;
                        state   <= ST_SENSE;
                    end
                end
                ST_SENSE: begin
                    cur_row <= nxt_row;
                    state   <= ST_OPEN;
                end
                ST_OPEN: begin
                    if (row_open) begin
                        nxt_row  <= req_row;
                        reopen_q <= 1'b1;
                        state    <= ST_WB;
                    end else if (row_close) begin
                        reopen_q <= 1'b0;
                        state    <= ST_WB;
                    end
                end
                ST_WB: begin
                    state <= reopen_q ? ST_SENSE : ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_BUSY_NOT_OPEN: assert property (@(posedge clk) disable iff (rst)
        !(busy && active)); // R2
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        acc_err |-> ($past(col_acc) && !$past(active))); // R7
endmodule

// File: rtl/dram_row_emu.sv
module dram_row_emu
    import dram_emu_pkg::*;
#(
    parameter int HALF_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2*HALF_W-1:0] addr,
    input  logic                row_open,
    input  logic                row_close,
    input  logic                col_acc,
    input  logic                col_we,
    input  logic                wdata,
    output logic                rdata,
    output logic                rdata_vld,
    output logic                busy,
    output logic                row_active,
    output logic                acc_err
);
    localparam int COLS = 1 << HALF_W;

    logic [HALF_W-1:0] a_row;
    logic [HALF_W-1:0] a_col;
    logic [HALF_W-1:0] cur_row;
    logic [HALF_W-1:0] nxt_row;
    logic [COLS-1:0]   sense_data;
    logic [COLS-1:0]   latch_q;
    logic [COLS-1:0]   row_valid;
    arr_cmd_t          cmd;

    dram_addr_split #(.HALF_W(HALF_W)) u_split (
        .addr (addr),
        .row  (a_row),
        .col  (a_col)
    );

    dram_ctrl #(.HALF_W(HALF_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .row_open  (row_open),
        .row_close (row_close),
        .col_acc   (col_acc),
        .col_we    (col_we),
        .req_row   (a_row),
        .cmd       (cmd),
        .cur_row   (cur_row),
        .nxt_row   (nxt_row),
        .busy      (busy),
        .active    (row_active),
        .acc_err   (acc_err)
    );

    dram_cell_array #(.HALF_W(HALF_W)) u_array (
        .clk        (clk),
        .rst        (rst),
        .sense_en   (cmd.sense),
        .sense_row  (nxt_row),
        .wb_en      (cmd.wback),
        .wb_row     (cur_row),
        .wb_data    (latch_q),
        .sense_data (sense_data),
        .row_valid  (row_valid)
    );

    dram_row_latch #(.HALF_W(HALF_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .load_en   (cmd.sense),
        .load_data (sense_data),
        .col       (a_col),
        .rd_en     (cmd.lat_rd),
        .wr_en     (cmd.lat_wr),
        .wbit      (wdata),
        .latch_q   (latch_q),
        .rdata     (rdata),
        .rdata_vld (rdata_vld)
    );

    AST_OPEN_ROW_INVALID: assert property (@(posedge clk) disable iff (rst)
        row_active |-> !row_valid[cur_row]); // R3
    AST_WB_RESTORES: assert property (@(posedge clk) disable iff (rst)
        cmd.wback |=> row_valid[$past(cur_row)]); // R4
    AST_RVLD_SOURCE: assert property (@(posedge clk) disable iff (rst)
        rdata_vld |-> ($past(row_active) && $past(col_acc) && !$past(col_we))); // R6
endmodule

// File: tb/dram_row_emu_bench.sv
module dram_row_emu_bench;
    localparam int HALF_W = 2;
    localparam int AW     = 2 * HALF_W;
    localparam int NVEC   = 20;

    // entry: {op[1:0], addr[3:0], wbit, expected}; op 0=open 1=close 2=write 3=read
    localparam logic [7:0] VEC [NVEC] = '{
        {2'd0, 4'd4,  2'b00}, {2'd2, 4'd6,  2'b10}, {2'd2, 4'd4,  2'b00},
        {2'd2, 4'd7,  2'b10}, {2'd3, 4'd6,  2'b01}, {2'd3, 4'd5,  2'b00},
        {2'd1, 4'd0,  2'b00}, {2'd0, 4'd8,  2'b00}, {2'd2, 4'd9,  2'b10},
        {2'd3, 4'd9,  2'b01}, {2'd3, 4'd10, 2'b00}, {2'd0, 4'd4,  2'b00},
        {2'd3, 4'd6,  2'b01}, {2'd3, 4'd7,  2'b01}, {2'd3, 4'd4,  2'b00},
        {2'd1, 4'd0,  2'b00}, {2'd0, 4'd8,  2'b00}, {2'd3, 4'd9,  2'b01},
        {2'd3, 4'd8,  2'b00}, {2'd1, 4'd0,  2'b00}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          row_open = 1'b0;
    logic          row_close = 1'b0;
    logic          col_acc = 1'b0;
    logic          col_we = 1'b0;
    logic          wdata = 1'b0;
    logic          rdata;
    logic          rdata_vld;
    logic          busy;
    logic          row_active;
    logic          acc_err;

    int checks = 0;
    int errors = 0;
    bit is_open = 1'b0;

    always #2 clk = ~clk;

    dram_row_emu #(.HALF_W(HALF_W)) u_dram_row_emu (
        .clk(clk), .rst(rst), .addr(addr), .row_open(row_open),
        .row_close(row_close), .col_acc(col_acc), .col_we(col_we),
        .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld), .busy(busy),
        .row_active(row_active), .acc_err(acc_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_open(input logic [AW-1:0] a);
        addr = a; row_open = 1'b1;
        tick();
        row_open = 1'b0;
        if (is_open) begin
            chk("R8 busy in writeback", int'(busy), 1);
            tick();
        end
        chk("R2 busy in sense", int'(busy), 1);
        tick();
        chk("R2 busy after sense", int'(busy), 0);
        chk("R2 row active", int'(row_active), 1);
        is_open = 1'b1;
    endtask

    task automatic do_close();
        row_close = 1'b1;
        tick();
        row_close = 1'b0;
        chk("R4 busy in writeback", int'(busy), 1);
        tick();
        chk("R4 closed", int'(row_active), 0);
        is_open = 1'b0;
    endtask

    task automatic do_wr(input logic [AW-1:0] a, input logic v);
        addr = a; col_acc = 1'b1; col_we = 1'b1; wdata = v;
        tick();
        col_acc = 1'b0; col_we = 1'b0;
        chk("R5 write accepted", int'(acc_err), 0);
    endtask

    task automatic do_rd(input logic [AW-1:0] a, input logic e);
        addr = a; col_acc = 1'b1; col_we = 1'b0;
        tick();
        col_acc = 1'b0;
        chk("R6 read valid", int'(rdata_vld), 1);
        chk("R1 R6 read data", int'(rdata), int'(e));
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        // R10 reset state
        chk("R10 busy", int'(busy), 0);
        chk("R10 active", int'(row_active), 0);
        chk("R10 err", int'(acc_err), 0);
        chk("R10 rvld", int'(rdata_vld), 0);

        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][7:6])
                2'd0: do_open(VEC[i][5:2]);
                2'd1: do_close();
                2'd2: do_wr(VEC[i][5:2], VEC[i][1]);
                default: do_rd(VEC[i][5:2], VEC[i][0]);
            endcase
        end

        // R7: access with no row open
        addr = 4'd3; col_acc = 1'b1; col_we = 1'b1; wdata = 1'b1;
        tick();
        col_acc = 1'b0; col_we = 1'b0;
        chk("R7 err pulse", int'(acc_err), 1);
        tick();
        chk("R7 err one cycle", int'(acc_err), 0);
        col_acc = 1'b1;
        tick();
        col_acc = 1'b0;
        chk("R7 no rvld when closed", int'(rdata_vld), 0);
        chk("R7 err on read", int'(acc_err), 1);

        // R10 cells zero, R7 write ignored
        do_open(4'd0);
        do_rd(4'd3, 1'b0);
        do_rd(4'd0, 1'b0);
        tick();
        chk("R6 rvld single cycle", int'(rdata_vld), 0);

        // R11 open and close together: open wins
        addr = 4'd12; row_open = 1'b1; row_close = 1'b1;
        tick();
        row_open = 1'b0; row_close = 1'b0;
        chk("R11 busy writeback", int'(busy), 1);
        tick();
        chk("R11 busy sense", int'(busy), 1);
        tick();
        chk("R11 new row active", int'(row_active), 1);
        do_rd(4'd12, 1'b0);
        do_wr(4'd15, 1'b1);

        // R9 strobes and access during writeback
        row_close = 1'b1;
        tick();
        row_close = 1'b0;
        chk("R9 in writeback", int'(busy), 1);
        addr = 4'd4; row_open = 1'b1; col_acc = 1'b1;
        tick();
        row_open = 1'b0; col_acc = 1'b0;
        chk("R9 err during busy", int'(acc_err), 1);
        chk("R9 closed", int'(row_active), 0);
        tick();
        chk("R9 open strobe ignored", int'(busy), 0);
        chk("R9 still closed", int'(row_active), 0);
        is_open = 1'b0;

        // R4 R5 data survives close and reopen
        do_open(4'd12);
        do_rd(4'd15, 1'b1);
        do_rd(4'd14, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule